// File: doc/BRIEF.md
# Receive Frame Slot Writer

This block accepts received Ethernet frames as a byte stream and places each one into a fixed-size slot of a shared packet buffer. The slots form a small ring at the bottom of the buffer; slot `k` starts at byte address `k * SLOT_BYTES`. When a frame ends cleanly, the block records its slot number and byte count and raises a pending event. Software then reads the slot and length from word registers, copies the frame out, and writes the pending register to hand the slot back.

Frames that cannot be stored are discarded and counted. There are three cases: no slot is free when the frame begins, the frame is longer than a slot, or the upstream checker flags the frame as bad on its last byte. The error count saturates. The stream side never stalls. An enable bit decides whether a pending event drives the interrupt line.

Top module: `rxslot_writer`

## Requirements
- R1: After reset, the pending, slot, length, error-count and enable registers all read 0, `irq` is 0 and `rx_ready` is 1.
- R2: A frame of N bytes (1 ≤ N ≤ SLOT_BYTES) that has `rx_bad` low on its last byte is written byte i to buffer address slot·SLOT_BYTES + i. Once the last byte is accepted, the pending register (word 0x10, bit 0) reads 1, the slot register (0x00) reads the slot index and the length register (0x04) reads N.
- R3: Stored frames take slots 0, 1, … in arrival order and wrap at NUM_SLOTS. They are presented to software in the same order. Slot and length stay fixed until the presented frame is acknowledged.
- R4: Writing a word with bit 0 set to 0x10 releases the presented slot and presents the next stored frame, if there is one. Writing bit 0 as 0 has no effect.
- R5: A frame whose first byte arrives while every slot is occupied produces no buffer writes. It is counted once in the error register (0x08).
- R6: A frame longer than SLOT_BYTES has only its first SLOT_BYTES bytes written. It is counted as an error and never presented. A frame of exactly SLOT_BYTES bytes is stored normally.
- R7: A frame with `rx_bad` high on its last byte is counted as an error and not presented. Its slot is reused by the next frame.
- R8: The error register increments once per discarded frame and holds at 2^ERR_W − 1.
- R9: The enable register (0x14, bit 0) can be read and written. `irq` is 1 exactly when a frame is pending and enable is 1.
- R10: The status register (0x0C) reads the pending bit. Unmapped or misaligned addresses read 0. Writes to read-only registers change nothing.
- R11: `rx_ready` is always 1. Bytes that cannot be stored are discarded, and the stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream ready, constant 1 |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_bad | input | 1 | Frame status from upstream, sampled with the last byte |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from the address |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | clog2(NUM_SLOTS·SLOT_BYTES) | Buffer byte address |
| buf_wdata | output | 8 | Buffer write byte |
| irq | output | 1 | Interrupt, pending AND enable |

## Verification
The bench builds the block with two slots of 8 bytes and a 2-bit error counter. These small values let it do three things in a few dozen cycles: overflow a slot with a 9-byte frame, fill the ring so that a third frame is refused, and push the error count to its ceiling of 3 and then past it. Two slots also make the ring wrap several times, which exercises both the slot order and the reuse of a slot after a rejected frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_SKIP = 2'd2
    } rx_state_e;

    // Word indices within the register window (byte address / 4)
    localparam logic [2:0] REG_SLOT = 3'd0;
    localparam logic [2:0] REG_LEN  = 3'd1;
    localparam logic [2:0] REG_ERR  = 3'd2;
    localparam logic [2:0] REG_STAT = 3'd3;
    localparam logic [2:0] REG_PEND = 3'd4;
    localparam logic [2:0] REG_EN   = 3'd5;

    localparam int unsigned CSR_AW = 5;
    localparam int unsigned CSR_DW = 32;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rxw_ingest.sv
module rxw_ingest
    import rxw_pkg::*;
#(
    parameter int unsigned SLOT_BYTES = 2048,
    parameter int unsigned SLOT_W     = 1,
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned BUF_AW     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_bad,
    input  logic              slot_free,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              commit,
    output logic [LEN_W-1:0]  commit_len,
    output logic              frame_err
);

    rx_state_e        st_q;
    logic [LEN_W-1:0] fill_q;
    logic             trunc_q;

    logic             start, take, room, trunc_now, done;
    logic [LEN_W-1:0] cur_len;

    always_comb begin
        start      = in_valid && (st_q == RX_IDLE);
        take       = (st_q == RX_FILL) || (start && slot_free);
        cur_len    = start ? '0 : fill_q;
        room       = cur_len < LEN_W'(SLOT_BYTES);
        trunc_now  = (trunc_q && (st_q == RX_FILL)) || !room;
        done       = in_valid && in_last && take;
        buf_we     = in_valid && take && room;
        buf_addr   = BUF_AW'(32'(slot_idx) * 32'(SLOT_BYTES) + 32'(cur_len));
        buf_wdata  = in_data;
        commit     = done && !in_bad && !trunc_now;
        commit_len = cur_len + 1'b1;
        frame_err  = (done && !commit) || (in_valid && in_last && !take);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RX_IDLE;
            fill_q  <= '0;
            trunc_q <= 1'b0;
        end else if (in_valid) begin
            if (in_last)
                st_q <= RX_IDLE;
            else if (st_q == RX_IDLE)
                st_q <= slot_free ? RX_FILL : RX_SKIP;
            if (take) begin
                fill_q  <= room ? cur_len + 1'b1 : cur_len;
                trunc_q <= trunc_now;
            end
        end
    end

    // R5: a refused frame never touches the buffer
    a_r5_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_SKIP) |-> !buf_we);

    // R6: the fill count never passes the slot size
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_FILL) |-> (fill_q <= LEN_W'(SLOT_BYTES)));

    // R6: a committed length always fits the slot
    a_r6_commit_fits: assert property (@(posedge clk) disable iff (rst)
        commit |-> (commit_len <= LEN_W'(SLOT_BYTES)));

endmodule

// File: rtl/rxw_ring.sv
module rxw_ring #(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned SLOT_W    = 1,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned CNT_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [LEN_W-1:0]  commit_len,
    input  logic              release_req,
    output logic              slot_free,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              head_valid,
    output logic [SLOT_W-1:0] head_slot,
    output logic [LEN_W-1:0]  head_len
);

    logic [SLOT_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q [NUM_SLOTS];
    logic              rel;

    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rel        = release_req && (cnt_q != '0);
    assign slot_free  = cnt_q < CNT_W'(NUM_SLOTS);
    assign wr_slot    = wr_q;
    assign head_valid = cnt_q != '0;
    assign head_slot  = rd_q;
    assign head_len   = len_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (commit) wr_q <= bump(wr_q);
            if (rel)    rd_q <= bump(rd_q);
            if (commit && !rel)
                cnt_q <= cnt_q + 1'b1;
            else if (rel && !commit)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_len
            always_ff @(posedge clk) begin
                if (rst)
                    len_q[g] <= '0;
                else if (commit && (wr_q == SLOT_W'(g)))
                    len_q[g] <= commit_len;
            end
        end
    endgenerate

    // R3: occupancy never exceeds the ring
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NUM_SLOTS));

    // R3: a commit only happens into a reserved free slot
    a_r3_commit_room: assert property (@(posedge clk) disable iff (rst)
        commit |-> (cnt_q < CNT_W'(NUM_SLOTS)));

    // R4: an acknowledge without a new commit drains one entry
    a_r4_release_drains: assert property (@(posedge clk) disable iff (rst)
        (rel && !commit) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/rxw_csr.sv
module rxw_csr
    import rxw_pkg::*;
#(
    parameter int unsigned ERR_W  = 32,
    parameter int unsigned SLOT_W = 1,
    parameter int unsigned LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic              head_valid,
    input  logic [SLOT_W-1:0] head_slot,
    input  logic [LEN_W-1:0]  head_len,
    input  logic              frame_err,
    output logic              release_req,
    output logic              irq
);

    logic [ERR_W-1:0] err_q;
    logic             en_q;
    logic             aligned;
    logic [2:0]       word;
    logic             unused_wdata;

    assign aligned      = csr_addr[1:0] == 2'b00;
    assign word         = csr_addr[4:2];
    assign unused_wdata = ^csr_wdata[CSR_DW-1:1];
    assign release_req  = csr_we && aligned && (word == REG_PEND) && csr_wdata[0];
    assign irq          = head_valid && en_q;

    always_comb begin
        csr_rdata = '0;
        if (aligned) begin
            case (word)
                REG_SLOT: csr_rdata = CSR_DW'(head_slot);
                REG_LEN:  csr_rdata = CSR_DW'(head_len);
                REG_ERR:  csr_rdata = CSR_DW'(err_q);
                REG_STAT: csr_rdata = CSR_DW'(head_valid);
                REG_PEND: csr_rdata = CSR_DW'(head_valid);
                REG_EN:   csr_rdata = CSR_DW'(en_q);
                default:  csr_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (frame_err && (err_q != '1))
                err_q <= err_q + 1'b1;
            if (csr_we && aligned && (word == REG_EN))
                en_q <= csr_wdata[0];
        end
    end

    // R8: the error count sticks at its ceiling
    a_r8_err_holds_max: assert property (@(posedge clk) disable iff (rst)
        (err_q == '1) |=> (err_q == '1));

    // R9: an enable write lands in the next cycle
    a_r9_enable_write: assert property (@(posedge clk) disable iff (rst)
        (csr_we && aligned && (word == REG_EN)) |=> (en_q == $past(csr_wdata[0])));

endmodule

// File: rtl/rxslot_writer.sv
module rxslot_writer
    import rxw_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 2,
    parameter int unsigned SLOT_BYTES = 2048,
    parameter int unsigned ERR_W      = 32
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    rx_valid,
    output logic                                    rx_ready,
    input  logic [7:0]                              rx_data,
    input  logic                                    rx_last,
    input  logic                                    rx_bad,
    input  logic                                    csr_we,
    input  logic [4:0]                              csr_addr,
    input  logic [31:0]                             csr_wdata,
    output logic [31:0]                             csr_rdata,
    output logic                                    buf_we,
    output logic [$clog2(NUM_SLOTS*SLOT_BYTES)-1:0] buf_addr,
    output logic [7:0]                              buf_wdata,
    output logic                                    irq
);

    localparam int unsigned SLOT_W = idx_bits(NUM_SLOTS);
    localparam int unsigned LEN_W  = $clog2(SLOT_BYTES + 1);
    localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1);
    localparam int unsigned BUF_AW = $clog2(NUM_SLOTS * SLOT_BYTES);

    logic              slot_free, commit, frame_err, release_req, head_valid;
    logic [SLOT_W-1:0] wr_slot, head_slot;
    logic [LEN_W-1:0]  commit_len, head_len;

    assign rx_ready = 1'b1;

    rxw_ingest #(
        .SLOT_BYTES(SLOT_BYTES), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .BUF_AW(BUF_AW)
    ) u_ingest (
        .clk(clk), .rst(rst),
        .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last), .in_bad(rx_bad),
        .slot_free(slot_free), .slot_idx(wr_slot),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .commit(commit), .commit_len(commit_len), .frame_err(frame_err)
    );

    rxw_ring #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_ring (
        .clk(clk), .rst(rst),
        .commit(commit), .commit_len(commit_len), .release_req(release_req),
        .slot_free(slot_free), .wr_slot(wr_slot),
        .head_valid(head_valid), .head_slot(head_slot), .head_len(head_len)
    );

    rxw_csr #(
        .ERR_W(ERR_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W)
    ) u_csr (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .head_valid(head_valid), .head_slot(head_slot), .head_len(head_len),
        .frame_err(frame_err), .release_req(release_req), .irq(irq)
    );

    // R3: the presented frame holds still until it is acknowledged
    a_r3_head_stable: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !release_req) |=> ($stable(head_slot) && $stable(head_len)));

    // R2: a frame is only committed while the ring reports room
    a_r2_commit_has_slot: assert property (@(posedge clk) disable iff (rst)
        commit |-> slot_free);

    // R11: the stream is never throttled
    a_r11_always_ready: assert property (@(posedge clk) disable iff (rst)
        rx_ready);

endmodule

// File: tb/sim_rxslot_writer.sv
module sim_rxslot_writer;

    localparam int NS = 2;
    localparam int SB = 8;
    localparam int EW = 2;
    localparam int EMAX = (1 << EW) - 1;

    // {length[5:1], bad[0]}
    localparam logic [5:0] VEC [6] = '{
        {5'd3, 1'b0}, {5'd8, 1'b0}, {5'd9, 1'b0},
        {5'd5, 1'b1}, {5'd1, 1'b0}, {5'd4, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_bad = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        csr_we = 1'b0;
    logic [4:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        buf_we, irq;
    logic [3:0]  buf_addr;
    logic [7:0]  buf_wdata;

    int checks = 0, failures = 0, wcount = 0;
    bit finished = 1'b0;
    logic [7:0] mem [16];

    always #2 clk = ~clk;

    rxslot_writer #(.NUM_SLOTS(NS), .SLOT_BYTES(SB), .ERR_W(EW)) u0 (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_bad(rx_bad),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst && buf_we) begin
            mem[buf_addr] = buf_wdata;
            wcount++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic csr_rd(input int a, output int v);
        @(negedge clk);
        csr_addr = 5'(a);
        #1 v = int'(csr_rdata);
    endtask

    task automatic csr_wr(input int a, input int d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 5'(a); csr_wdata = 32'(d);
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic send(input int len, input int tag, input bit bad);
        @(negedge clk);
        wcount = 0;
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(tag * 16 + i);
            rx_last  = (i == len - 1);
            rx_bad   = bad && (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_bad = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, exp_slot, exp_err, len, tag;
        bit bad, acc;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        csr_rd(32'h10, v); chk("R1 pending", v, 0);
        csr_rd(32'h00, v); chk("R1 slot", v, 0);
        csr_rd(32'h04, v); chk("R1 length", v, 0);
        csr_rd(32'h08, v); chk("R1 errors", v, 0);
        csr_rd(32'h14, v); chk("R1 enable", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R11 ready", int'(rx_ready), 1);

        exp_slot = 0; exp_err = 0;
        for (int k = 0; k < 6; k++) begin
            len = int'(VEC[k][5:1]);
            bad = VEC[k][0];
            tag = k + 1;
            acc = !bad && (len <= SB);
            send(len, tag, bad);
            csr_rd(32'h10, v); chk("R2 pending after frame", v, int'(acc));
            if (acc) begin
                csr_rd(32'h00, v); chk("R3 slot order", v, exp_slot);
                csr_rd(32'h04, v); chk("R2 length", v, len);
                chk("R2 write count", wcount, len);
                for (int i = 0; i < len; i++)
                    chk("R2 buffer byte", int'(mem[exp_slot * SB + i]), tag * 16 + i);
                csr_wr(32'h10, 1);
                csr_rd(32'h10, v); chk("R4 released", v, 0);
                exp_slot = (exp_slot + 1) % NS;
            end else begin
                exp_err = (exp_err < EMAX) ? exp_err + 1 : EMAX;
                csr_rd(32'h08, v); chk("R6 R7 error count", v, exp_err);
                if (len > SB) chk("R6 truncated writes", wcount, SB);
                if (bad)      chk("R7 bad frame writes", wcount, len);
            end
        end

        // R9: interrupt gating
        csr_wr(32'h14, 1);
        csr_rd(32'h14, v); chk("R9 enable readback", v, 1);
        send(2, 10, 1'b0);
        chk("R9 irq with enable", int'(irq), 1);
        // R10: status, holes, misaligned, read-only writes
        csr_rd(32'h0C, v); chk("R10 status", v, 1);
        csr_rd(32'h18, v); chk("R10 unmapped", v, 0);
        csr_rd(32'h02, v); chk("R10 misaligned", v, 0);
        csr_wr(32'h04, 99);
        csr_rd(32'h04, v); chk("R10 length read-only", v, 2);
        csr_wr(32'h14, 0);
        #1 chk("R9 irq disabled", int'(irq), 0);
        csr_rd(32'h10, v); chk("R9 pending kept", v, 1);

        // R5: fill the ring then refuse a frame
        send(6, 11, 1'b0);
        send(3, 12, 1'b0);
        chk("R5 no writes when full", wcount, 0);
        csr_rd(32'h08, v); chk("R5 drop counted", v, EMAX);
        chk("R11 ready while full", int'(rx_ready), 1);

        // R4: a zero write leaves the slot held
        csr_wr(32'h10, 0);
        csr_rd(32'h10, v); chk("R4 zero write ignored", v, 1);

        // R3: arrival order and stable head
        csr_rd(32'h00, v); chk("R3 first slot", v, 0);
        csr_rd(32'h04, v); chk("R3 first length", v, 2);
        csr_wr(32'h10, 1);
        csr_rd(32'h00, v); chk("R3 second slot", v, 1);
        csr_rd(32'h04, v); chk("R3 second length", v, 6);
        chk("R3 second data", int'(mem[SB + 5]), 11 * 16 + 5);
        csr_wr(32'h10, 1);
        csr_rd(32'h10, v); chk("R4 ring empty", v, 0);

        // R8: saturation holds
        send(2, 13, 1'b1);
        csr_rd(32'h08, v); chk("R8 saturated", v, EMAX);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule